// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block is the software-facing register file of a simple DMA channel. A host reads and writes four 32-bit word registers through a register bus: a control/status word, a transfer address, a byte count and an upper-address base. Actual data movement, address translation and FIFO storage belong to neighbouring logic. This block drives two control lines toward that logic: a one-cycle peripheral reset pulse and a DMA enable level. It receives two things back: an interrupt request from the attached device, and a completion strobe with a byte count that advances the transfer address.

The control/status word carries an interrupt pending flag and an interrupt enable, and a level interrupt output follows from them. Several of its bits are locked against software and are only changed by hardware. A fixed version code always reads back in the top bits. A write of all zeros is treated as a request to drain the FIFO. Writing the transfer address raises a flag that records the address has been loaded.

The parameter `WIDE_WIN` selects a 32-byte register window. In that window, the four registers appear twice and offsets beyond the window read as zero. The default narrow window decodes only byte-offset bits [3:2]. The bus accepts a request in every cycle. Read data returns one cycle after the request is accepted.

Top module: `dmacr_top`

## Requirements
- R1: After reset, the control/status word (index 0) reads 0xA0000000, indices 1 to 3 read zero, and `irq_out`, `dma_en` and `periph_rst` are low.
- R2: `bus_ready` is always high. A read accepted at one clock edge gives `rd_valid` high and `rd_data` equal to the register selected by byte-offset bits [3:2] after the next edge. Indices 2 (count) and 3 (base) store any written value unchanged.
- R3: Control/status bits under mask 0xFE000007 keep their old value on a software write, and bits 31 and 29 (the version, 0xA0000000) always read as one. Writing 0xFFFFFFFF to a word holding 0xA4000000 therefore reads back 0xA5FFFFF8.
- R4: A rising `irq_in` sets the pending bit (bit 0) and raises `irq_out` if the interrupt enable (bit 4) is set. A falling `irq_in` clears the pending bit and drops `irq_out` if the enable is set.
- R5: A control/status write with bit 4 set raises `irq_out` if pending is already set. A write with bit 4 clear drops `irq_out` if pending or enable was set. `irq_out` is never high while bit 4 is clear.
- R6: A control/status write with bit 7 set gives `periph_rst` high for exactly the one cycle after the write.
- R7: When bit 7 is clear, a written drain bit (bit 6) is stored as zero. A write of exactly zero stores bit 6 as one.
- R8: `dma_en` rises when control/status bit 9 changes from 0 to 1, and falls when it changes from 1 to 0.
- R9: Any write to index 1 stores the value and sets the loaded bit (bit 26) of control/status. Writes to other indices leave bit 26 unchanged.
- R10: A `xfer_done` strobe adds `xfer_len` to the index-1 address register, once per strobe cycle.
- R11: With `WIDE_WIN`=1, offsets 16 to 31 alias the four registers, offsets above 31 read zero, and writes there are ignored. With `WIDE_WIN`=0, offset bits above bit 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| irq_in | input | 1 | Interrupt request from the attached device |
| irq_out | output | 1 | Interrupt output to the host |
| periph_rst | output | 1 | One-cycle reset pulse to the attached device |
| dma_en | output | 1 | DMA enable level |
| xfer_done | input | 1 | Transfer completion strobe |
| xfer_len | input | LEN_W | Bytes moved by the completed transfer |

## Verification
Assertions check the following on every cycle: the version bits, the rule that an interrupt output implies the enable bit, the enable output tracking bit 9, the single-cycle origin of each reset pulse, the loaded flag after an address write, read latency, and the zero return outside the wide window. Only the bench scenarios can show the exact stored values. These include the locked-bit merge, the drain rewrite of a zero write, pending and output sequences across edges of the interrupt input, the accumulation of transfer lengths, and aliasing in both window variants.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;

    localparam int DW = 32;

    localparam logic [DW-1:0] CSR_RESET  = 32'hA000_0000;
    localparam logic [DW-1:0] CSR_LOCKED = 32'hFE00_0007;

    localparam int B_PEND   = 0;
    localparam int B_IEN    = 4;
    localparam int B_DRAIN  = 6;
    localparam int B_PRST   = 7;
    localparam int B_TOMEM  = 8;
    localparam int B_DMAEN  = 9;
    localparam int B_LOADED = 26;

    typedef enum logic [1:0] {
        IDX_CSR   = 2'd0,
        IDX_ADDR  = 2'd1,
        IDX_COUNT = 2'd2,
        IDX_BASE  = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic           valid;
        logic           write;
        logic           hit;
        reg_idx_e       idx;
        logic [DW-1:0]  data;
    } bus_req_t;

    // Drain rules applied to a written command word.
    function automatic logic [DW-1:0] csr_cmd_fix(logic [DW-1:0] w);
        logic [DW-1:0] v;
        v = w;
        if (!w[B_PRST]) begin
            if (w[B_DRAIN])
                v[B_DRAIN] = 1'b0;
            else if (w == '0)
                v[B_DRAIN] = 1'b1;
        end
        return v;
    endfunction

    // Locked bits keep the old value, the version is forced.
    function automatic logic [DW-1:0] csr_merge(logic [DW-1:0] old_v,
                                                 logic [DW-1:0] new_v);
        return (old_v & CSR_LOCKED) | (new_v & ~CSR_LOCKED) | CSR_RESET;
    endfunction

endpackage

// File: rtl/dmacr_decode.sv
module dmacr_decode
    import dmacr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter bit WIDE_WIN = 1'b0
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output bus_req_t          req
);
    localparam int WIN_BITS = 5;

    logic hit;
    logic unused_bits;

    generate
        if (WIDE_WIN) begin : g_wide
            assign hit = (bus_addr[ADDR_W-1:WIN_BITS] == '0);
        end else begin : g_narrow
            assign hit = 1'b1;
        end
    endgenerate

    assign unused_bits = ^{bus_addr[ADDR_W-1:4], bus_addr[1:0]};

    always_comb begin
        req.valid = bus_valid;
        req.write = bus_write;
        req.hit   = hit;
        req.idx   = reg_idx_e'(bus_addr[3:2]);
        req.data  = bus_wdata;
    end
endmodule

// File: rtl/dmacr_csr.sv
module dmacr_csr
    import dmacr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic          irq_in,
    output logic [DW-1:0] csr_q,
    output logic          irq_out,
    output logic          periph_rst,
    output logic          dma_en
);
    logic          irq_prev;
    logic          csr_wr, addr_wr;
    logic          rise, fall;
    logic [DW-1:0] cmd, csr_n;
    logic          irq_n, prst_n, en_n;

    assign csr_wr  = req.valid && req.write && req.hit && (req.idx == IDX_CSR);
    assign addr_wr = req.valid && req.write && req.hit && (req.idx == IDX_ADDR);
    assign rise    = irq_in && !irq_prev;
    assign fall    = !irq_in && irq_prev;
    assign cmd     = csr_cmd_fix(req.data);

    always_comb begin
        csr_n  = csr_q;
        irq_n  = irq_out;
        prst_n = 1'b0;
        if (csr_wr) begin
            prst_n = req.data[B_PRST];
            if (cmd[B_IEN]) begin
                if (csr_q[B_PEND]) irq_n = 1'b1;
            end else if (csr_q[B_PEND] || csr_q[B_IEN]) begin
                irq_n = 1'b0;
            end
            csr_n = csr_merge(csr_q, cmd);
        end
        if (addr_wr)
            csr_n[B_LOADED] = 1'b1;
        if (rise) begin
            csr_n[B_PEND] = 1'b1;
            if (csr_n[B_IEN]) irq_n = 1'b1;
        end else if (fall && csr_n[B_PEND]) begin
            csr_n[B_PEND] = 1'b0;
            if (csr_n[B_IEN]) irq_n = 1'b0;
        end
        en_n = dma_en;
        if (csr_n[B_DMAEN] && !csr_q[B_DMAEN])
            en_n = 1'b1;
        else if (!csr_n[B_DMAEN] && csr_q[B_DMAEN])
            en_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q      <= CSR_RESET;
            irq_out    <= 1'b0;
            periph_rst <= 1'b0;
            dma_en     <= 1'b0;
            irq_prev   <= 1'b0;
        end else begin
            csr_q      <= csr_n;
            irq_out    <= irq_n;
            periph_rst <= prst_n;
            dma_en     <= en_n;
            irq_prev   <= irq_in;
        end
    end

    // R3: version bits always present
    p_version_r3: assert property (@(posedge clk) disable iff (rst)
        csr_q[31] && csr_q[29]);

    // R5: output only while enabled
    p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> csr_q[B_IEN]);

    // R8: enable output tracks the stored bit
    p_en_track_r8: assert property (@(posedge clk) disable iff (rst)
        dma_en == csr_q[B_DMAEN]);

    // R6: each pulse comes from a write with bit 7 set
    p_prst_src_r6: assert property (@(posedge clk) disable iff (rst)
        periph_rst |-> $past(csr_wr && req.data[B_PRST]));

    // R9: address write leaves loaded bit set
    p_loaded_r9: assert property (@(posedge clk) disable iff (rst)
        addr_wr |=> csr_q[B_LOADED]);

    // R4: rising interrupt input sets pending
    p_pend_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_in && !irq_prev) |=> csr_q[B_PEND]);
endmodule

// File: rtl/dmacr_data.sv
module dmacr_data
    import dmacr_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  bus_req_t               req,
    input  logic                   xfer_done,
    input  logic [LEN_W-1:0]       xfer_len,
    output logic [2:0][DW-1:0]     data_q
);
    localparam int NDATA = 3;

    logic [DW-1:0] len_ext;
    assign len_ext = DW'(xfer_len);

    generate
        for (genvar i = 0; i < NDATA; i++) begin : g_reg
            localparam logic [1:0] MY_IDX = 2'(i + 1);
            logic wr;
            assign wr = req.valid && req.write && req.hit && (req.idx == reg_idx_e'(MY_IDX));
            if (i == 0) begin : g_ptr
                always_ff @(posedge clk) begin
                    if (rst)
                        data_q[i] <= '0;
                    else if (wr)
                        data_q[i] <= req.data;
                    else if (xfer_done)
                        data_q[i] <= data_q[i] + len_ext;
                end
            end else begin : g_plain
                always_ff @(posedge clk) begin
                    if (rst)
                        data_q[i] <= '0;
                    else if (wr)
                        data_q[i] <= req.data;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dmacr_top.sv
module dmacr_top
    import dmacr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int LEN_W    = 16,
    parameter bit WIDE_WIN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              irq_in,
    output logic              irq_out,
    output logic              periph_rst,
    output logic              dma_en,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_len
);
    bus_req_t          req;
    logic [DW-1:0]     csr_q;
    logic [2:0][DW-1:0] data_q;
    logic [DW-1:0]     mux;

    assign bus_ready = 1'b1;

    dmacr_decode #(.ADDR_W(ADDR_W), .WIDE_WIN(WIDE_WIN)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req       (req)
    );

    dmacr_csr u_csr (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .irq_in     (irq_in),
        .csr_q      (csr_q),
        .irq_out    (irq_out),
        .periph_rst (periph_rst),
        .dma_en     (dma_en)
    );

    dmacr_data #(.LEN_W(LEN_W)) u_data (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .xfer_done (xfer_done),
        .xfer_len  (xfer_len),
        .data_q    (data_q)
    );

    always_comb begin
        case (req.idx)
            IDX_CSR:   mux = csr_q;
            IDX_ADDR:  mux = data_q[0];
            IDX_COUNT: mux = data_q[1];
            default:   mux = data_q[2];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write)
                rd_data <= req.hit ? mux : '0;
        end
    end

    // R2: one-cycle read latency
    p_rd_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> rd_valid);

    // R11: reads outside the window return zero
    p_miss_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !req.hit) |=> (rd_data == '0));
endmodule

// File: tb/dmacr_top_tb.sv
module dmacr_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic irq_in = 1'b0, xfer_done = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;

    logic n_ready, n_rdv, n_irq, n_prst, n_en;
    logic [31:0] n_rdata;
    logic w_ready, w_rdv, w_irq, w_prst, w_en;
    logic [31:0] w_rdata;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmacr_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WIDE_WIN(1'b0)) u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(n_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_valid(n_rdv), .rd_data(n_rdata), .irq_in(irq_in), .irq_out(n_irq),
        .periph_rst(n_prst), .dma_en(n_en), .xfer_done(xfer_done), .xfer_len(xfer_len));

    dmacr_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WIDE_WIN(1'b1)) u_dut_wide (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(w_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_valid(w_rdv), .rd_data(w_rdata), .irq_in(irq_in), .irq_out(w_irq),
        .periph_rst(w_prst), .dma_en(w_en), .xfer_done(xfer_done), .xfer_len(xfer_len));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] dn,
                      output logic [31:0] dw, output logic vn);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        dn = n_rdata; dw = w_rdata; vn = n_rdv;
        bus_valid = 1'b0;
    endtask

    task automatic set_irq(input logic v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] dn, dw; logic v;
        check("R1 irq_out", {31'd0, n_irq}, 0);
        check("R1 dma_en", {31'd0, n_en}, 0);
        check("R1 periph_rst", {31'd0, n_prst}, 0);
        check("R2 ready", {31'd0, n_ready}, 1);
        rd(8'h00, dn, dw, v);
        check("R1 csr", dn, 32'hA000_0000);
        check("R2 rd_valid", {31'd0, v}, 1);
        rd(8'h04, dn, dw, v); check("R1 addr", dn, 0);
        rd(8'h08, dn, dw, v); check("R1 count", dn, 0);
        rd(8'h0C, dn, dw, v); check("R1 base", dn, 0);
    endtask

    task automatic t_regs();
        logic [31:0] dn, dw; logic v;
        wr(8'h08, 32'h1234_5678);
        wr(8'h0C, 32'hDEAD_0000);
        rd(8'h08, dn, dw, v); check("R2 count", dn, 32'h1234_5678);
        rd(8'h0C, dn, dw, v); check("R2 base", dn, 32'hDEAD_0000);
        rd(8'h00, dn, dw, v); check("R9 no loaded", dn, 32'hA000_0000);
        wr(8'h04, 32'h0000_1000);
        rd(8'h04, dn, dw, v); check("R9 addr", dn, 32'h0000_1000);
        rd(8'h00, dn, dw, v); check("R9 loaded", dn, 32'hA400_0000);
    endtask

    task automatic t_drain();
        logic [31:0] dn, dw; logic v;
        wr(8'h00, 32'h0);
        rd(8'h00, dn, dw, v); check("R7 zero write", dn, 32'hA400_0040);
        wr(8'h00, 32'h40);
        rd(8'h00, dn, dw, v); check("R7 drain cleared", dn, 32'hA400_0000);
    endtask

    task automatic t_locked();
        logic [31:0] dn, dw; logic v;
        wr(8'h00, 32'hFFFF_FFFF);
        check("R6 pulse", {31'd0, n_prst}, 1);
        check("R8 en rise", {31'd0, n_en}, 1);
        check("R5 no pend", {31'd0, n_irq}, 0);
        @(negedge clk);
        check("R6 one cycle", {31'd0, n_prst}, 0);
        rd(8'h00, dn, dw, v); check("R3 locked", dn, 32'hA5FF_FFF8);
        wr(8'h00, 32'h10);
        check("R8 en fall", {31'd0, n_en}, 0);
        check("R6 no pulse", {31'd0, n_prst}, 0);
        rd(8'h00, dn, dw, v); check("R3 merge", dn, 32'hA400_0010);
    endtask

    task automatic t_irq();
        logic [31:0] dn, dw; logic v;
        set_irq(1'b1);
        check("R4 rise out", {31'd0, n_irq}, 1);
        rd(8'h00, dn, dw, v); check("R4 pend set", dn, 32'hA400_0011);
        set_irq(1'b0);
        check("R4 fall out", {31'd0, n_irq}, 0);
        rd(8'h00, dn, dw, v); check("R4 pend clr", dn, 32'hA400_0010);
        wr(8'h00, 32'h0);
        set_irq(1'b1);
        check("R4 masked", {31'd0, n_irq}, 0);
        rd(8'h00, dn, dw, v); check("R4 masked pend", dn, 32'hA400_0041);
        wr(8'h00, 32'h10);
        check("R5 enable raises", {31'd0, n_irq}, 1);
        rd(8'h00, dn, dw, v); check("R5 pend kept", dn, 32'hA400_0011);
        wr(8'h00, 32'h0);
        check("R5 disable lowers", {31'd0, n_irq}, 0);
        set_irq(1'b0);
        rd(8'h00, dn, dw, v); check("R4 pend off", dn, 32'hA400_0040);
    endtask

    task automatic t_xfer();
        logic [31:0] dn, dw; logic v;
        wr(8'h04, 32'h100);
        @(negedge clk); xfer_done = 1'b1; xfer_len = 16'h20;
        @(negedge clk); xfer_done = 1'b0;
        rd(8'h04, dn, dw, v); check("R10 single", dn, 32'h120);
        @(negedge clk); xfer_done = 1'b1; xfer_len = 16'h3;
        @(negedge clk);
        @(negedge clk); xfer_done = 1'b0;
        rd(8'h04, dn, dw, v); check("R10 double", dn, 32'h126);
    endtask

    task automatic t_window();
        logic [31:0] dn, dw; logic v;
        wr(8'h18, 32'h55);
        rd(8'h08, dn, dw, v);
        check("R11 wide alias", dw, 32'h55);
        check("R11 narrow alias", dn, 32'h55);
        wr(8'h28, 32'h77);
        rd(8'h08, dn, dw, v);
        check("R11 wide ignore", dw, 32'h55);
        check("R11 narrow high bits", dn, 32'h77);
        rd(8'h28, dn, dw, v);
        check("R11 wide zero", dw, 32'h0);
        check("R11 narrow read", dn, 32'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_drain();
        t_locked();
        t_irq();
        t_xfer();
        t_window();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule